// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block raises the DMA request pulses for a UART whose receiver and transmitter each have a FIFO. It watches the receive FIFO fill level, an error flag on the entry at the head of that FIFO, and a pulse from the receiver's idle timeout. It also watches the transmit FIFO's empty flag, a pulse that marks each move of a byte into the transmit shift register, and the control bit that holds the transmitter in reset. From these it produces two one-clock request pulses: one that asks a DMA channel to drain the receiver and one that asks it to refill the transmitter.

Requests are not queued. If a DMA channel is not armed when a pulse arrives, that pulse is lost, and nothing more happens until a new condition fires. Each pulse marks the start of a condition, not a level, so a FIFO that stays above its trigger does not raise repeated requests. When FIFO mode is off, the block stays silent.

Top module: `uart_dma_req_gen`

## Requirements
- R1: The 2-bit `trig_sel` field sets the receive threshold: 0 means 1 character, 1 means 4, 2 means 8 and 3 means 14. The threshold is clamped to the FIFO depth. If in some cycle `fifo_en` is 1, `rx_head_err` is 0 and `rx_level` is at or above the threshold, and that condition was false in the previous cycle, then `rx_dma_req` is 1 in the following cycle.
- R2: While the receive condition of R1 stays true from one cycle to the next, no further level-driven pulse is issued. A new level pulse needs the condition to become false and then true again.
- R3: A cycle with `rx_timeout` at 1, `fifo_en` at 1 and `rx_head_err` at 0 gives `rx_dma_req` at 1 in the next cycle, whatever the fill level.
- R4: In a cycle with `rx_head_err` at 1, neither a level match nor a timeout raises `rx_dma_req` in the following cycle.
- R5: If `rx_head_err` falls while `fifo_en` is 1 and the level is still at or above the threshold, exactly one receive pulse follows in the next cycle.
- R6: A cycle with `tx_load` at 1 and `tx_empty` at 1 (the load took the last entry), in FIFO mode, gives `tx_dma_req` at 1 in the next cycle. A load that leaves data behind (`tx_empty` at 0) gives no pulse.
- R7: A 0-to-1 transition of `tx_run` (the transmitter leaving reset) gives a `tx_dma_req` pulse in the next cycle, but only when `fifo_en` is 1 in the cycle `tx_run` first reads 1.
- R8: In any cycle with `fifo_en` at 0, neither output pulses in the next cycle. Conditions seen while disabled are not stored and not replayed later.
- R9: While `rst` is 1, and in the first cycle after it is released, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_en | input | 1 | FIFO mode enable |
| trig_sel | input | 2 | Receive threshold select (1/4/8/14 characters) |
| rx_level | input | LVL_W (5) | Receive FIFO fill level |
| rx_head_err | input | 1 | Entry at the head of the receive FIFO is erroneous |
| rx_timeout | input | 1 | One-cycle receiver timeout pulse |
| tx_empty | input | 1 | Transmit FIFO holds no data after this cycle's pop |
| tx_load | input | 1 | One-cycle pulse: byte moved into the transmit shift register |
| tx_run | input | 1 | Transmitter reset-control bit (1 = running) |
| rx_dma_req | output | 1 | One-cycle receive DMA request |
| tx_dma_req | output | 1 | One-cycle transmit DMA request |

## Verification
On every cycle, the assertions check the following: silence in non-FIFO mode, suppression under a head error, a guaranteed pulse after a timeout or a draining load, the absence of repeats while the receive condition holds steady, and that every transmit pulse has a legal cause in the cycle before it. The bench scenarios cover the remaining behaviour. These include each threshold encoding at its exact crossing point, a single pulse when an error clears over a full FIFO, the reset-release pulse counted once per edge and only in FIFO mode, and the fact that conditions seen while disabled are dropped rather than replayed. A fixed-seed random walk of the fill level, mixed with sporadic errors and timeouts, is checked against an independent reference model.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;

    typedef enum logic [1:0] {
        TRG_ONE      = 2'd0,
        TRG_FOUR     = 2'd1,
        TRG_EIGHT    = 2'd2,
        TRG_FOURTEEN = 2'd3
    } trig_sel_e;

    // Causes that may start a receive request.
    typedef struct packed {
        logic level_rise;
        logic timeout;
    } rx_cause_t;

    // Causes that may start a transmit request.
    typedef struct packed {
        logic drained;
        logic released;
    } tx_cause_t;

    function automatic int unsigned trig_chars(input trig_sel_e sel);
        case (sel)
            TRG_ONE:   return 1;
            TRG_FOUR:  return 4;
            TRG_EIGHT: return 8;
            default:   return 14;
        endcase
    endfunction

    // Threshold limited to what the FIFO can actually hold.
    function automatic int unsigned trig_clamped(input trig_sel_e sel, input int unsigned depth);
        int unsigned t;
        t = trig_chars(sel);
        return (t > depth) ? depth : t;
    endfunction

endpackage

// File: rtl/udr_rise_det.sv
module udr_rise_det #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] sig,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= '0;
        else     sig_q <= sig;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign rise[i] = sig[i] & ~sig_q[i];
    end
endmodule

// File: rtl/udr_rx_path.sv
module udr_rx_path
    import uart_dma_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  trig_sel_e        trig_sel,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_head_err,
    input  logic             rx_timeout,
    output rx_cause_t        cause
);
    logic [LVL_W-1:0] thresh;
    logic             ok_to_req;
    logic             level_met;
    logic             cond;
    logic             cond_rise;

    always_comb begin
        thresh    = LVL_W'(trig_clamped(trig_sel, FIFO_DEPTH));
        ok_to_req = fifo_en & ~rx_head_err;
        level_met = (rx_level >= thresh);
        cond      = ok_to_req & level_met;
    end

    udr_rise_det #(.WIDTH(1)) u_cond_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  (cond),
        .rise (cond_rise)
    );

    always_comb begin
        cause.level_rise = cond_rise;
        cause.timeout    = ok_to_req & rx_timeout;
    end
endmodule

// File: rtl/udr_tx_path.sv
module udr_tx_path
    import uart_dma_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fifo_en,
    input  logic      tx_empty,
    input  logic      tx_load,
    input  logic      tx_run,
    output tx_cause_t cause
);
    logic run_rise;

    udr_rise_det #(.WIDTH(1)) u_run_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  (tx_run),
        .rise (run_rise)
    );

    always_comb begin
        cause.drained  = fifo_en & tx_load & tx_empty;
        cause.released = fifo_en & run_rise;
    end
endmodule

// File: rtl/uart_dma_req_gen.sv
module uart_dma_req_gen
    import uart_dma_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_head_err,
    input  logic             rx_timeout,
    input  logic             tx_empty,
    input  logic             tx_load,
    input  logic             tx_run,
    output logic             rx_dma_req,
    output logic             tx_dma_req
);
    rx_cause_t rx_cause;
    tx_cause_t tx_cause;
    trig_sel_e sel;

    assign sel = trig_sel_e'(trig_sel);

    udr_rx_path #(.FIFO_DEPTH(FIFO_DEPTH)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .fifo_en     (fifo_en),
        .trig_sel    (sel),
        .rx_level    (rx_level),
        .rx_head_err (rx_head_err),
        .rx_timeout  (rx_timeout),
        .cause       (rx_cause)
    );

    udr_tx_path u_tx (
        .clk      (clk),
        .rst      (rst),
        .fifo_en  (fifo_en),
        .tx_empty (tx_empty),
        .tx_load  (tx_load),
        .tx_run   (tx_run),
        .cause    (tx_cause)
    );

    // Registered request stage: pulses leave one cycle after their cause.
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_dma_req <= 1'b0;
            tx_dma_req <= 1'b0;
        end else begin
            rx_dma_req <= |rx_cause;
            tx_dma_req <= |tx_cause;
        end
    end
endmodule

// File: rtl/udr_checker.sv
module udr_checker
    import uart_dma_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_en,
    input logic [1:0]       trig_sel,
    input logic [LVL_W-1:0] rx_level,
    input logic             rx_head_err,
    input logic             rx_timeout,
    input logic             tx_empty,
    input logic             tx_load,
    input logic             tx_run,
    input logic             rx_dma_req,
    input logic             tx_dma_req
);
    logic             past_ok;
    logic [LVL_W-1:0] thr;
    logic             met;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assign thr = LVL_W'(trig_clamped(trig_sel_e'(trig_sel), FIFO_DEPTH));
    assign met = fifo_en & ~rx_head_err & (rx_level >= thr);

    AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |=> (!rx_dma_req && !tx_dma_req)); // R8

    AST_ERR_BLOCKS_RX: assert property (@(posedge clk) disable iff (rst)
        rx_head_err |=> !rx_dma_req); // R4

    AST_TIMEOUT_RX: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && rx_timeout && !rx_head_err) |=> rx_dma_req); // R3

    AST_NO_REPEAT_RX: assert property (@(posedge clk) disable iff (rst)
        (past_ok && met && $past(met) && !rx_timeout) |=> !rx_dma_req); // R2

    AST_DRAIN_TX: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && tx_load && tx_empty) |=> tx_dma_req); // R6

    AST_TX_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (past_ok && tx_dma_req) |-> $past(fifo_en && ((tx_load && tx_empty) || tx_run))); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        (past_ok && $past(rst)) |-> (!rx_dma_req && !tx_dma_req)); // R9
endmodule

bind uart_dma_req_gen udr_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_udr_chk (
    .clk         (clk),
    .rst         (rst),
    .fifo_en     (fifo_en),
    .trig_sel    (trig_sel),
    .rx_level    (rx_level),
    .rx_head_err (rx_head_err),
    .rx_timeout  (rx_timeout),
    .tx_empty    (tx_empty),
    .tx_load     (tx_load),
    .tx_run      (tx_run),
    .rx_dma_req  (rx_dma_req),
    .tx_dma_req  (tx_dma_req)
);

// File: tb/uart_dma_req_gen_bench.sv
module uart_dma_req_gen_bench;
    localparam int DEPTH = 16;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fifo_en = 1'b0;
    logic [1:0]    trig_sel = 2'd0;
    logic [LW-1:0] rx_level = '0;
    logic          rx_head_err = 1'b0;
    logic          rx_timeout = 1'b0;
    logic          tx_empty = 1'b0;
    logic          tx_load = 1'b0;
    logic          tx_run = 1'b0;
    logic          rx_dma_req;
    logic          tx_dma_req;

    always #5 clk = ~clk;

    uart_dma_req_gen #(.FIFO_DEPTH(DEPTH)) u_uart_dma_req_gen (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .rx_level(rx_level), .rx_head_err(rx_head_err), .rx_timeout(rx_timeout),
        .tx_empty(tx_empty), .tx_load(tx_load), .tx_run(tx_run),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 0;
    bit    m_cond_q = 0, m_run_q = 0, m_err_q = 0;
    bit    exp_rx = 0, exp_tx = 0;
    string tag_rx = "R9", tag_tx = "R9";
    int    cur_lvl = 0;

    function automatic int thr_of(input logic [1:0] s);
        int t;
        case (s)
            2'd0: t = 1;
            2'd1: t = 4;
            2'd2: t = 8;
            default: t = 14;
        endcase
        return (t > DEPTH) ? DEPTH : t;
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Drive one cycle of inputs and predict the outputs of the next cycle.
    task automatic apply(input bit en, input logic [1:0] sel, input int lvl, input bit err,
                         input bit to, input bit emp, input bit ld, input bit run);
        bit cond, rise;
        if (lvl < 0) lvl = 0;
        if (lvl > DEPTH) lvl = DEPTH;
        cur_lvl = lvl;
        fifo_en = en; trig_sel = sel; rx_level = LW'(lvl); rx_head_err = err;
        rx_timeout = to; tx_empty = emp; tx_load = ld; tx_run = run;
        cond   = en && !err && (lvl >= thr_of(sel));
        rise   = cond && !m_cond_q;
        exp_rx = en && !err && (rise || to);
        exp_tx = en && ((ld && emp) || (run && !m_run_q));
        if (!en)                 tag_rx = "R8";
        else if (err)            tag_rx = "R4";
        else if (to)             tag_rx = "R3";
        else if (rise && m_err_q) tag_rx = "R5";
        else if (cond && m_cond_q) tag_rx = "R2";
        else                     tag_rx = "R1";
        if (!en)                 tag_tx = "R8";
        else if (run && !m_run_q) tag_tx = "R7";
        else                     tag_tx = "R6";
        m_cond_q = cond; m_run_q = run; m_err_q = err;
    endtask

    task automatic step(input bit en, input logic [1:0] sel, input int lvl, input bit err,
                        input bit to, input bit emp, input bit ld, input bit run);
        @(negedge clk);
        check(tag_rx, "rx_dma_req", rx_dma_req, exp_rx);
        check(tag_tx, "tx_dma_req", tx_dma_req, exp_tx);
        apply(en, sel, lvl, err, to, emp, ld, run);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL R9 watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        // R9: quiet during reset
        repeat (3) begin
            @(negedge clk);
            check("R9", "rx_dma_req in reset", rx_dma_req, 1'b0);
            check("R9", "tx_dma_req in reset", tx_dma_req, 1'b0);
        end
        @(negedge clk);
        rst = 0;
        apply(1, 2'd0, 0, 0, 0, 0, 0, 0);

        // R1 each threshold encoding: approach, cross, hold, drop, re-cross
        for (int s = 0; s < 4; s++) begin
            int t;
            t = thr_of(2'(s));
            step(1, 2'(s), 0, 0, 0, 0, 0, 0);
            step(1, 2'(s), t - 1, 0, 0, 0, 0, 0);
            step(1, 2'(s), t, 0, 0, 0, 0, 0);      // R1 crossing
            step(1, 2'(s), t + 1, 0, 0, 0, 0, 0);  // R2 no repeat
            step(1, 2'(s), t + 1, 0, 0, 0, 0, 0);
            step(1, 2'(s), t - 1, 0, 0, 0, 0, 0);
            step(1, 2'(s), t, 0, 0, 0, 0, 0);      // R2 re-cross
        end
        // R3 timeout at empty FIFO, and back to back
        step(1, 2'd2, 0, 0, 1, 0, 0, 0);
        step(1, 2'd2, 0, 0, 1, 0, 0, 0);
        step(1, 2'd2, 0, 0, 0, 0, 0, 0);
        // R4 error blocks crossing and timeout; R5 clear gives one pulse
        step(1, 2'd1, 6, 1, 0, 0, 0, 0);
        step(1, 2'd1, 6, 1, 1, 0, 0, 0);
        step(1, 2'd1, 6, 0, 0, 0, 0, 0);
        step(1, 2'd1, 6, 0, 0, 0, 0, 0);
        step(1, 2'd1, 0, 0, 0, 0, 0, 0);
        // R6 drain load vs non-drain load
        step(1, 2'd1, 0, 0, 0, 0, 1, 0);
        step(1, 2'd1, 0, 0, 0, 1, 1, 0);
        step(1, 2'd1, 0, 0, 0, 1, 0, 0);
        // R7 release edge enabled, held, then edge while disabled
        step(1, 2'd1, 0, 0, 0, 1, 0, 1);
        step(1, 2'd1, 0, 0, 0, 1, 0, 1);
        step(1, 2'd1, 0, 0, 0, 1, 0, 0);
        step(0, 2'd1, 0, 0, 0, 1, 0, 1);
        // R8 disabled: timeout, drain, crossing, all dropped
        step(0, 2'd0, 5, 0, 1, 1, 1, 1);
        step(0, 2'd0, 5, 0, 1, 1, 1, 1);
        step(1, 2'd3, 0, 0, 0, 0, 0, 1);
        step(1, 2'd3, 0, 0, 0, 0, 0, 1);

        // Constrained random walk
        begin
            bit en = 1, run = 1;
            logic [1:0] sel = 2'd1;
            int lvl = 0;
            for (int i = 0; i < 4000; i++) begin
                int r;
                r = int'($urandom_range(0, 2));
                lvl = lvl + r - 1;
                if (lvl < 0) lvl = 0;
                if (lvl > DEPTH) lvl = DEPTH;
                if ($urandom_range(0, 39) == 0) en = ~en;
                if ($urandom_range(0, 59) == 0) sel = 2'($urandom_range(0, 3));
                if ($urandom_range(0, 79) == 0) run = ~run;
                step(en, sel, lvl, $urandom_range(0, 7) == 0, $urandom_range(0, 19) == 0,
                     $urandom_range(0, 2) == 0, $urandom_range(0, 4) == 0, run);
            end
        end
        step(1, 2'd0, 0, 0, 0, 0, 0, 1);
        step(1, 2'd0, 0, 0, 0, 0, 0, 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule